// File: doc/BRIEF.md
# Physical address cacheability classifier

This block sits directly after address translation. It inspects each physical address, up to 44 bits wide, and classifies it. The access is marked uncacheable when either of two candidate uncached-marker bits is set. Two marker positions are accepted because two addressing conventions are in use: one places the marker at bit 39 and the other at bit 40.

Uncacheable addresses that fall in the internal register window are flagged as errors. Speculative requests never raise this error. For superpage and direct-mapped accesses, the block also produces the adjusted physical address.

An optional monitor keeps one sticky record for each marker convention seen since reset. It reports an error when an access uses the opposite convention. All results are registered and appear one cycle after the request, qualified by an output valid.

Top module: `pa_cache_classifier`

## Requirements
- R1: An accepted request is reported uncacheable exactly when address bit 39 or bit 40 is 1.
- R2: An uncacheable, non-speculative request whose address is at or above the register-window base (default 0xFFFFFF00000) raises the register error. A speculative request (in_spec=1) never raises it.
- R3: The register-window comparison only matters for uncacheable requests. A cacheable address at or above the base raises no register error.
- R4: For a superpage request (in_superpage=1) with bit 39 or bit 40 set, output bits 43:40 are all ones and bits 39:0 are passed through.
- R5: For a superpage request with neither marker bit set, output bits 43:40 are zero and bits 39:0 are passed through. A non-superpage address is passed through unchanged.
- R6: When the monitor is enabled, a bit-40 uncached request raises the mix error if any bit-39 uncached request was accepted earlier since reset. A request with both bits set counts as bit-40 convention.
- R7: When the monitor is enabled, a bit-39-only uncached request raises the mix error if any bit-40 uncached request was accepted earlier since reset. Repeating the same convention never raises it.
- R8: While reset (rst_n=0, asynchronous, active low) is asserted, all outputs are zero and both sticky convention records are cleared.
- R9: Outputs appear one clock after the request, and out_valid follows in_valid with that latency. All flags are zero when out_valid is 0. Cycles with in_valid=0 leave the sticky records unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | 44 | Physical address from translation |
| in_spec | input | 1 | Request is speculative |
| in_superpage | input | 1 | Request took the superpage/direct path |
| out_valid | output | 1 | Registered request valid |
| out_uncached | output | 1 | Request is uncacheable |
| out_reg_err | output | 1 | Non-speculative access to the register window |
| out_mix_err | output | 1 | Marker conventions mixed since reset |
| out_addr | output | 44 | Adjusted physical address |

## Verification
The bench builds two copies side by side.

The first copy uses the default parameters, with the monitor enabled. With these defaults every address in the register window already has bit 39 set, so R3 cannot be observed on it.

The second copy lowers the register-window base to bit 24 and disables the monitor. This lets a cacheable address reach the window, so the bench can check that such an address raises no error.

// File: rtl/pa_cache_classifier.sv
module pa_cache_classifier #(
  parameter int              PA_W       = 44,
  parameter int              UNC_LO_BIT = 39,
  parameter int              UNC_HI_BIT = 40,
  parameter logic [PA_W-1:0] REG_BASE   = 44'hFFFFFF00000,
  parameter bit              MIX_MON    = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PA_W-1:0] in_addr,
  input  logic            in_spec,
  input  logic            in_superpage,
  output logic            out_valid,
  output logic            out_uncached,
  output logic            out_reg_err,
  output logic            out_mix_err,
  output logic [PA_W-1:0] out_addr
);
  localparam int KEEP_W = UNC_HI_BIT;
  localparam int EXT_W  = PA_W - KEEP_W;

  logic mark_hi, mark_lo, unc, reg_err_d, mix_d;
  logic [PA_W-1:0] addr_d;

  assign mark_hi   = in_addr[UNC_HI_BIT];
  assign mark_lo   = in_addr[UNC_LO_BIT];
  assign unc       = mark_hi | mark_lo;
  assign reg_err_d = unc & (in_addr >= REG_BASE) & ~in_spec;
  assign addr_d    = in_superpage ? {{EXT_W{unc}}, in_addr[KEEP_W-1:0]} : in_addr;

  generate
    if (MIX_MON) begin : g_mon
      logic seen_lo, seen_hi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seen_lo <= 1'b0;
          seen_hi <= 1'b0;
        end else if (in_valid && mark_hi) begin
          seen_hi <= 1'b1;
        end else if (in_valid && mark_lo) begin
          seen_lo <= 1'b1;
        end
      end
      assign mix_d = in_valid & (mark_hi ? seen_lo : (mark_lo & seen_hi));
    end else begin : g_nomon
      assign mix_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_uncached <= 1'b0;
      out_reg_err  <= 1'b0;
      out_mix_err  <= 1'b0;
      out_addr     <= '0;
    end else begin
      out_valid    <= in_valid;
      out_uncached <= in_valid & unc;
      out_reg_err  <= in_valid & reg_err_d;
      out_mix_err  <= mix_d;
      if (in_valid) out_addr <= addr_d;
    end
  end
endmodule

// File: rtl/pa_cache_classifier_chk.sv
module pa_cache_classifier_chk #(
  parameter int PA_W       = 44,
  parameter int UNC_LO_BIT = 39,
  parameter int UNC_HI_BIT = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [PA_W-1:0] in_addr,
  input logic            in_spec,
  input logic            in_superpage,
  input logic            out_valid,
  input logic            out_uncached,
  input logic            out_reg_err,
  input logic            out_mix_err,
  input logic [PA_W-1:0] out_addr
);
  a_r1_marker_uncached: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_addr[UNC_LO_BIT] || in_addr[UNC_HI_BIT]) |=> out_uncached);

  a_r2_spec_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_spec |=> !out_reg_err);

  a_r3_err_needs_unc: assert property (@(posedge clk) disable iff (!rst_n)
    out_reg_err |-> out_uncached);

  a_r4_superpage_ext: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_superpage && (in_addr[UNC_LO_BIT] || in_addr[UNC_HI_BIT])
    |=> (&out_addr[PA_W-1:UNC_HI_BIT]));

  a_r6_mix_needs_unc: assert property (@(posedge clk) disable iff (!rst_n)
    out_mix_err |-> out_uncached);

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_uncached && !out_reg_err && !out_mix_err);
endmodule

bind pa_cache_classifier pa_cache_classifier_chk #(
  .PA_W(PA_W), .UNC_LO_BIT(UNC_LO_BIT), .UNC_HI_BIT(UNC_HI_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
  .in_spec(in_spec), .in_superpage(in_superpage), .out_valid(out_valid),
  .out_uncached(out_uncached), .out_reg_err(out_reg_err),
  .out_mix_err(out_mix_err), .out_addr(out_addr)
);

// File: tb/tb_pa_cache_classifier.sv
module tb_pa_cache_classifier;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [43:0] in_addr = '0;
  logic in_spec = 1'b0;
  logic in_superpage = 1'b0;
  logic out_valid, out_uncached, out_reg_err, out_mix_err;
  logic [43:0] out_addr;
  logic lo_valid, lo_uncached, lo_reg_err, lo_mix_err;
  logic [43:0] lo_addr;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  pa_cache_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_spec(in_spec), .in_superpage(in_superpage), .out_valid(out_valid),
    .out_uncached(out_uncached), .out_reg_err(out_reg_err),
    .out_mix_err(out_mix_err), .out_addr(out_addr));

  pa_cache_classifier #(.REG_BASE(44'h00001000000), .MIX_MON(1'b0)) dut_lo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_spec(in_spec), .in_superpage(in_superpage), .out_valid(lo_valid),
    .out_uncached(lo_uncached), .out_reg_err(lo_reg_err),
    .out_mix_err(lo_mix_err), .out_addr(lo_addr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs settled.
  task automatic drive(input logic v, input logic [43:0] a, input logic s, input logic sp);
    in_valid = v; in_addr = a; in_spec = s; in_superpage = sp;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 valid", 64'(out_valid), 0);
    chk("R8 flags", 64'({out_uncached, out_reg_err, out_mix_err}), 0);
    chk("R8 addr", 64'(out_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_uncached();
    drive(1, 44'h01234567000, 0, 0);
    chk("R1 cacheable", 64'(out_uncached), 0);
    chk("R9 valid", 64'(out_valid), 1);
    drive(1, 44'h08000000000, 0, 0);
    chk("R1 bit39", 64'(out_uncached), 1);
    drive(1, 44'h10000000000, 0, 0);
    chk("R1 bit40", 64'(out_uncached), 1);
  endtask

  task automatic t_regwin();
    drive(1, 44'hFFFFFF00000, 0, 0);
    chk("R2 at base", 64'(out_reg_err), 1);
    drive(1, 44'hFFFFFFFFFFF, 0, 0);
    chk("R2 top", 64'(out_reg_err), 1);
    drive(1, 44'hFFFFFEFFFFF, 0, 0);
    chk("R2 below base", 64'(out_reg_err), 0);
    drive(1, 44'hFFFFFF00000, 1, 0);
    chk("R2 speculative", 64'(out_reg_err), 0);
  endtask

  task automatic t_cacheable_window();
    drive(1, 44'h00020000000, 0, 0);
    chk("R3 cacheable in window unc", 64'(lo_uncached), 0);
    chk("R3 cacheable in window err", 64'(lo_reg_err), 0);
    drive(1, 44'h08020000000, 0, 0);
    chk("R3 uncached in window", 64'(lo_reg_err), 1);
  endtask

  task automatic t_superpage();
    drive(1, 44'h08012345678, 0, 1);
    chk("R4 bit39 ext", 64'(out_addr), 64'h0F8012345678);
    drive(1, 44'h10000000010, 0, 1);
    chk("R4 bit40 ext", 64'(out_addr), 64'h0F0000000010);
    drive(1, 44'h20000001234, 0, 1);
    chk("R5 truncate", 64'(out_addr), 64'h000000001234);
    drive(1, 44'h20000001234, 0, 0);
    chk("R5 passthrough", 64'(out_addr), 64'h020000001234);
  endtask

  task automatic t_mix_hi_after_lo();
    do_reset();
    drive(1, 44'h08000000000, 0, 0);
    chk("R6 first bit39", 64'(out_mix_err), 0);
    drive(1, 44'h08000000100, 0, 0);
    chk("R7 repeat bit39", 64'(out_mix_err), 0);
    drive(1, 44'h10000000000, 0, 0);
    chk("R6 bit40 after bit39", 64'(out_mix_err), 1);
  endtask

  task automatic t_mix_lo_after_hi();
    do_reset();
    drive(1, 44'h18000000000, 0, 0);
    chk("R6 both bits first", 64'(out_mix_err), 0);
    drive(1, 44'h10000000000, 0, 0);
    chk("R6 both bits count as bit40", 64'(out_mix_err), 0);
    drive(1, 44'h08000000000, 0, 0);
    chk("R7 bit39 after bit40", 64'(out_mix_err), 1);
  endtask

  task automatic t_idle_and_reset();
    do_reset();
    drive(0, 44'h08000000000, 0, 1);
    chk("R9 idle valid", 64'(out_valid), 0);
    chk("R9 idle flags", 64'({out_uncached, out_reg_err, out_mix_err}), 0);
    drive(1, 44'h10000000000, 0, 0);
    chk("R9 idle no sticky", 64'(out_mix_err), 0);
    do_reset();
    drive(1, 44'h08000000000, 0, 0);
    chk("R8 sticky cleared", 64'(out_mix_err), 0);
    drive(0, 44'h0, 0, 0);
    chk("R9 valid drops", 64'(out_valid), 0);
  endtask

  initial begin
    do_reset();
    t_uncached();
    t_regwin();
    t_cacheable_window();
    t_superpage();
    t_mix_hi_after_lo();
    t_mix_lo_after_hi();
    t_idle_and_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule